// File: doc/BRIEF.md
# Two-Level Slotted Bus Arbiter

This block decides which of several bus masters drives a shared bus. The first level is a timing wheel: a ring of slots, each reserved at build time for one master. A master with heavy traffic can be given several slots. When the master that owns the current slot asks for the bus, it wins. When that owner is silent, a second level hands the slot to another requester in round-robin order, so the bandwidth reserved for the slot is not left unused.

Arbitration happens only at rising clock edges and considers every request present at that edge. A grant is registered and one-hot. Once given, it stays on the same master until the bus signals that the access has ended. Whenever an access completes, the wheel moves to the next slot. While nobody requests, the wheel also moves on by itself after a fixed number of empty cycles. The slot-to-master map is a parameter and cannot be changed at run time.

Top module: `tdma_two_level_arbiter`

## Requirements
- R1: A synchronous active-high reset clears the grant, sets the slot output to 0 and resets the round-robin search, so that the first round-robin decision after reset starts its search at master 0.
- R2: While no grant is outstanding, if the master that owns the current slot is requesting at a clock edge, that master is granted.
- R3: While no grant is outstanding, if the slot owner is not requesting but another master is, the grant goes to the first requesting master found by searching upward in index order with wrap-around. The search starts at the master just after the most recent round-robin winner.
- R4: The round-robin search start changes only when a master wins through the second level. A grant won by a slot owner leaves it unchanged.
- R5: The grant is one-hot or all zero. A given grant stays unchanged until end-of-access is seen, even if the master withdraws its request.
- R6: When end-of-access is high at a clock edge while a grant is outstanding, the grant is all zero after that edge and the slot index has advanced by one, wrapping from N_SLOTS-1 to 0.
- R7: While no grant is outstanding and no master requests, the slot index advances by one after IDLE_LEN such consecutive edges, wrapping from N_SLOTS-1 to 0. With the default IDLE_LEN of 4, 64 empty edges after reset bring the slot back to 0.
- R8: No grant is issued at an edge where no master requests. End-of-access while no grant is outstanding has no effect on the grant or on the slot.
- R9: Slot s is owned by master SLOT_TABLE[s*MW +: MW], where MW = clog2(N_MASTERS). The default 16-slot table reads, from slot 0 upward, 0,1,0,2,0,3,0,1,0,2,0,3,0,1,0,2.
- R10: A grant decided at a clock edge is visible on the grant output immediately after that edge. The grant is encoded with bit i meaning master i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all decisions at its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | N_MASTERS | Request line per master, bit i for master i |
| done | input | 1 | End-of-access from the bus for the current grant |
| grant | output | N_MASTERS | Registered one-hot grant, all zero when the bus is free |
| slot | output | clog2(N_SLOTS) | Index of the current wheel slot |

## Verification
The properties assume that reset is held high through the first clock edges and that `done` is only meaningful while a grant is outstanding. The request lines and `done` may otherwise change freely from cycle to cycle, and `done` pulses while the bus is free must be tolerated and ignored. The stimulus changes inputs only in the middle of the clock period. It raises `done` both during real accesses and during idle cycles, and it drops a request while its grant is still held, so the ignore and hold rules are exercised within those assumptions.

// File: rtl/tdma_arb_pkg.sv
package tdma_arb_pkg;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_phase_e;

endpackage

// File: rtl/tdma_slot_wheel.sv
module tdma_slot_wheel #(
  parameter int N_SLOTS   = 16,
  parameter int N_MASTERS = 4,
  parameter int IDLE_LEN  = 4,
  localparam int SW  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int MW  = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
  parameter logic [N_SLOTS*MW-1:0] SLOT_TABLE = 32'h84C84C84
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          idle_tick,
  output logic [SW-1:0] slot,
  output logic [MW-1:0] owner
);

  localparam int ICW = (IDLE_LEN > 1) ? $clog2(IDLE_LEN) : 1;
  localparam logic [SW-1:0]  LAST_SLOT = SW'(N_SLOTS - 1);
  localparam logic [ICW-1:0] LAST_IDLE = ICW'(IDLE_LEN - 1);

  logic [SW-1:0]  slot_q;
  logic [ICW-1:0] idle_q;
  logic [MW-1:0]  owner_lut [N_SLOTS];
  logic           idle_wrap;
  logic           advance;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_lut
    assign owner_lut[s] = SLOT_TABLE[s*MW +: MW];
  end

  assign idle_wrap = idle_tick && (idle_q == LAST_IDLE);
  assign advance   = step || idle_wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= '0;
    end else if (idle_tick && !idle_wrap) begin
      idle_q <= idle_q + 1'b1;
    end else begin
      idle_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else if (advance) begin
      slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end
  end

  assign slot  = slot_q;
  assign owner = owner_lut[slot_q];

endmodule

// File: rtl/tdma_rr_picker.sv
module tdma_rr_picker #(
  parameter int N_MASTERS = 4,
  localparam int PW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 update,
  output logic [N_MASTERS-1:0] pick
);

  localparam logic [PW-1:0] LAST_M = PW'(N_MASTERS - 1);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] pick_idx;
  logic          found;
  int            cand;

  always_comb begin
    pick_idx = '0;
    found    = 1'b0;
    cand     = 0;
    for (int k = 0; k < N_MASTERS; k++) begin
      cand = int'(ptr_q) + k;
      if (cand >= N_MASTERS) cand = cand - N_MASTERS;
      if (!found && req[cand]) begin
        found    = 1'b1;
        pick_idx = PW'(cand);
      end
    end
  end

  assign pick = found ? (N_MASTERS'(1) << pick_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (update && found) begin
      ptr_q <= (pick_idx == LAST_M) ? '0 : pick_idx + 1'b1;
    end
  end

endmodule

// File: rtl/tdma_two_level_arbiter.sv
module tdma_two_level_arbiter
  import tdma_arb_pkg::*;
#(
  parameter int N_MASTERS = 4,
  parameter int N_SLOTS   = 16,
  parameter int IDLE_LEN  = 4,
  localparam int SW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int MW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
  parameter logic [N_SLOTS*MW-1:0] SLOT_TABLE = 32'h84C84C84
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_MASTERS-1:0] req,
  input  logic                 done,
  output logic [N_MASTERS-1:0] grant,
  output logic [SW-1:0]        slot
);

  arb_phase_e           phase_q;
  logic [N_MASTERS-1:0] grant_q;
  logic [MW-1:0]        owner_idx;
  logic [N_MASTERS-1:0] owner_oh;
  logic [N_MASTERS-1:0] rr_oh;
  logic                 owner_hit;
  logic                 any_req;
  logic                 busy;
  logic                 launch;
  logic                 finish;

  assign busy      = (phase_q == ARB_BUSY);
  assign any_req   = |req;
  assign owner_oh  = N_MASTERS'(1) << owner_idx;
  assign owner_hit = |(req & owner_oh);
  assign launch    = !busy && any_req;
  assign finish    = busy && done;

  tdma_slot_wheel #(
    .N_SLOTS   (N_SLOTS),
    .N_MASTERS (N_MASTERS),
    .IDLE_LEN  (IDLE_LEN),
    .SLOT_TABLE(SLOT_TABLE)
  ) u_wheel (
    .clk      (clk),
    .rst      (rst),
    .step     (finish),
    .idle_tick(!busy && !any_req),
    .slot     (slot),
    .owner    (owner_idx)
  );

  tdma_rr_picker #(
    .N_MASTERS(N_MASTERS)
  ) u_rr (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .update(launch && !owner_hit),
    .pick  (rr_oh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= ARB_IDLE;
      grant_q <= '0;
    end else begin
      case (phase_q)
        ARB_IDLE: begin
          if (launch) begin
            grant_q <= owner_hit ? owner_oh : rr_oh;
            phase_q <= ARB_BUSY;
          end
        end
        ARB_BUSY: begin
          if (done) begin
            grant_q <= '0;
            phase_q <= ARB_IDLE;
          end
        end
        default: begin
          grant_q <= '0;
          phase_q <= ARB_IDLE;
        end
      endcase
    end
  end

  assign grant = grant_q;

endmodule

// File: rtl/tdma_arb_checker.sv
module tdma_arb_checker #(
  parameter int N_MASTERS = 4,
  parameter int N_SLOTS   = 16,
  localparam int SW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int MW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N_MASTERS-1:0] req,
  input logic                 done,
  input logic [N_MASTERS-1:0] grant,
  input logic [SW-1:0]        slot,
  input logic [MW-1:0]        owner
);

  localparam logic [SW-1:0] LAST_SLOT = SW'(N_SLOTS - 1);

  p_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && !done) |=> $stable(grant));

  p_slot_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && !done) |=> $stable(slot));

  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && done) |=> (grant == '0));

  p_slot_step_r6: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && done) |=>
      (slot == (($past(slot) == LAST_SLOT) ? '0 : $past(slot) + 1'b1)));

  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (grant == '0 && req == '0) |=> (grant == '0));

  p_owner_first_r2: assert property (@(posedge clk) disable iff (rst)
    (grant == '0 && req[owner]) |=> (grant == (N_MASTERS'(1) << $past(owner))));

  p_grant_requester_r10: assert property (@(posedge clk) disable iff (rst)
    (grant == '0 && req != '0) |=> ((grant & $past(req)) != '0));

endmodule

bind tdma_two_level_arbiter tdma_arb_checker #(
  .N_MASTERS(N_MASTERS),
  .N_SLOTS  (N_SLOTS)
) u_chk (
  .clk  (clk),
  .rst  (rst),
  .req  (req),
  .done (done),
  .grant(grant),
  .slot (slot),
  .owner(owner_idx)
);

// File: tb/tdma_two_level_arbiter_test.sv
module tdma_two_level_arbiter_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] req = '0;
  logic       done = 1'b0;
  logic [3:0] grant;
  logic [3:0] slot;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tdma_two_level_arbiter uut (
    .clk  (clk),
    .rst  (rst),
    .req  (req),
    .done (done),
    .grant(grant),
    .slot (slot)
  );

  // fields: req[12:9] done[8] expected grant[7:4] expected slot[3:0]
  localparam int NV = 22;
  localparam logic [12:0] VEC [0:NV-1] = '{
    {4'b0010, 1'b0, 4'b0010, 4'd0},
    {4'b0001, 1'b0, 4'b0010, 4'd0},
    {4'b0011, 1'b1, 4'b0000, 4'd1},
    {4'b0011, 1'b0, 4'b0010, 4'd1},
    {4'b0001, 1'b1, 4'b0000, 4'd2},
    {4'b1100, 1'b0, 4'b0100, 4'd2},
    {4'b1100, 1'b1, 4'b0000, 4'd3},
    {4'b1001, 1'b0, 4'b1000, 4'd3},
    {4'b1001, 1'b1, 4'b0000, 4'd4},
    {4'b1110, 1'b0, 4'b0010, 4'd4},
    {4'b0000, 1'b1, 4'b0000, 4'd5},
    {4'b0000, 1'b0, 4'b0000, 4'd5},
    {4'b0000, 1'b0, 4'b0000, 4'd5},
    {4'b0000, 1'b0, 4'b0000, 4'd5},
    {4'b0000, 1'b0, 4'b0000, 4'd6},
    {4'b0001, 1'b0, 4'b0001, 4'd6},
    {4'b0000, 1'b1, 4'b0000, 4'd7},
    {4'b1111, 1'b0, 4'b0010, 4'd7},
    {4'b1111, 1'b1, 4'b0000, 4'd8},
    {4'b1110, 1'b0, 4'b0100, 4'd8},
    {4'b1110, 1'b1, 4'b0000, 4'd9},
    {4'b0000, 1'b1, 4'b0000, 4'd9}
  };
  localparam string TAGS [0:NV-1] = '{
    "R10", "R5", "R6", "R9", "R6", "R3", "R6", "R3", "R6", "R3", "R6",
    "R8", "R7", "R7", "R7", "R2", "R6", "R9", "R6", "R3", "R6", "R8"
  };

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] r, input logic d);
    req  = r;
    done = d;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: state after reset
    check("R1", "grant after reset", int'(grant), 0);
    check("R1", "slot after reset", int'(slot), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][12:9], VEC[i][8]);
      check(TAGS[i], $sformatf("vector %0d grant", i), int'(grant), int'(VEC[i][7:4]));
      check(TAGS[i], $sformatf("vector %0d slot", i), int'(slot), int'(VEC[i][3:0]));
    end

    // R3: search wraps from master 3 back to master 1 at slot 9
    step(4'b0010, 1'b0);
    check("R3", "wrapped rr pick", int'(grant), 4'b0010);

    // R1: reset in the middle of an access
    rst = 1'b1;
    step(4'b0010, 1'b0);
    check("R1", "grant after mid-access reset", int'(grant), 0);
    check("R1", "slot after mid-access reset", int'(slot), 0);
    rst = 1'b0;
    step(4'b0110, 1'b0);
    check("R1", "rr search starts at master 0", int'(grant), 4'b0010);

    // R7: four empty edges move slot 1 to slot 2
    step(4'b0000, 1'b1);
    check("R6", "slot after done", int'(slot), 1);
    step(4'b0000, 1'b0);
    step(4'b0000, 1'b0);
    step(4'b0000, 1'b0);
    check("R7", "slot before idle length", int'(slot), 1);
    step(4'b0000, 1'b0);
    check("R7", "slot after idle length", int'(slot), 2);

    // R2 and R4: owner win must not move the rr start
    step(4'b0111, 1'b0);
    check("R2", "slot owner granted", int'(grant), 4'b0001);
    step(4'b0000, 1'b1);
    step(4'b0011, 1'b0);
    check("R4", "rr start kept after owner win", int'(grant), 4'b0001);
    step(4'b0000, 1'b1);

    // R7: idle wrap of the whole wheel
    rst = 1'b1;
    step(4'b0000, 1'b0);
    rst = 1'b0;
    for (int k = 0; k < 60; k++) step(4'b0000, 1'b0);
    check("R7", "slot after 60 idle edges", int'(slot), 15);
    check("R8", "no grant without requests", int'(grant), 0);
    for (int k = 0; k < 4; k++) step(4'b0000, 1'b0);
    check("R7", "slot wrap after 64 idle edges", int'(slot), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule